// File: doc/BRIEF.md
# Programmable-Logic Configuration Bring-Up Sequencer

This block is a finite-state machine that readies a programmable-logic fabric for a full configuration load and releases it once the load has finished. It drives three things into the fabric. The first is a 4-bit fabric reset word. The second is a 4-bit level-shifter enable word. The third is an active-low program strobe. It watches two fabric inputs: an init status line and a configuration-done line.

A host issues a start command together with a partial-reconfiguration flag, streams the bitstream by other means, and then issues a finish command. On a full load, start drives the resets and shifters to fixed codes in a strict order. It then walks the program strobe through a high-low-high handshake, waiting at each step for the init line to follow. On a partial load, all fabric controls are left alone.

Every wait samples its input only once per poll interval and gives up after a timeout window. A timeout parks the block in an error state until the next start. Both intervals are parameters counted in clock cycles. The defaults correspond to a 20 µs poll and a 2.5 s timeout at 100 MHz, and a bench can shrink them.

Top module: `plcfg_bringup_seq`

## Requirements
- R1: After synchronous reset, fab_rst_o = 4'h0, lvl_en_o = 4'h0, prog_n_o = 1, and busy_o, ready_o, done_o and timeout_o are all 0.
- R2: A start accepted with partial_i = 0 updates the outputs on three consecutive cycles, starting in the cycle after start is sampled: fab_rst_o = 4'hF, then lvl_en_o = 4'h0, then lvl_en_o = 4'hA.
- R3: The strobe handshake runs in three steps. First, prog_n_o goes to 1 in the cycle after lvl_en_o reaches 4'hA, and the block waits for init_i = 1. Next, it drives prog_n_o = 0 and waits for init_i = 0. Last, it drives prog_n_o = 1 and waits for init_i = 1. Success of the last wait gives ready_o = 1 on the next cycle.
- R4: Cycle 0 of a wait is the first cycle in that wait. A wait samples its input only in wait cycles P-1, 2P-1, 3P-1 and so on, where P = POLL_CYCLES. A matching sample in cycle c changes the outputs in cycle c+1. A level that appears between samples is seen at the next sample.
- R5: If no sample in wait cycles 0 through TIMEOUT_CYCLES-1 matches, timeout_o rises in wait cycle TIMEOUT_CYCLES. A match at a sample falling exactly on cycle TIMEOUT_CYCLES-1 still counts as success.
- R6: A start accepted with partial_i = 1 leaves fab_rst_o, lvl_en_o and prog_n_o unchanged. It gives ready_o = 1 and timeout_o = 0 in the next cycle.
- R7: A finish sampled while ready_o = 1 starts a wait for cfg_done_i = 1, with the same poll and timeout rules. For a full load, success is followed by lvl_en_o = 4'hF on the next cycle, then fab_rst_o = 4'h0 on the cycle after, then done_o = 1 for exactly one cycle.
- R8: For a partial load, success of the configuration-done wait raises done_o for one cycle in the next cycle. The fabric controls are not changed.
- R9: While timeout_o = 1, all fabric outputs hold their values and timeout_o stays high until a start is sampled. A start then begins a new sequence.
- R10: busy_o is 1 in every sequencing and finish state and 0 in idle, ready and error. A start is ignored while busy_o or ready_o is 1. A finish is ignored unless ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command, sampled in idle or error |
| finish_i | input | 1 | Finish command, sampled in ready |
| partial_i | input | 1 | Partial-reconfiguration flag, captured with start |
| init_i | input | 1 | Fabric init status |
| cfg_done_i | input | 1 | Fabric configuration-done status |
| fab_rst_o | output | 4 | Fabric reset-control word |
| lvl_en_o | output | 4 | Level-shifter enable word |
| prog_n_o | output | 1 | Active-low program strobe |
| busy_o | output | 1 | Sequencing in progress |
| ready_o | output | 1 | Fabric prepared, waiting for finish |
| done_o | output | 1 | One-cycle pulse when the finish phase completes |
| timeout_o | output | 1 | A wait expired; held until the next start |

## Verification
The bench sweeps the response latency of each of the four waits across poll boundaries. This catches a design that samples every cycle, samples one cycle off the poll grid, or loses a match that lands on the final sample of the timeout window; any of these would leave a wait one or more cycles early or late. It checks, cycle by cycle, the order of the reset and shifter codes on both entry and release; a swapped order would briefly free fabric resets while the shifters are closed. It starts a partial load straight from an error state whose strobe is low, and a design that touched the fabric on a partial load would raise the strobe or rewrite a word there. It also pokes start and finish in states where they must be ignored, where a careless design would restart the sequence or skip a wait.

// File: rtl/plcfg_pkg.sv
`timescale 1ns/1ps
package plcfg_pkg;

    localparam int WORD_W = 4;
    typedef logic [WORD_W-1:0] word_t;

    // Fixed fabric codes
    localparam word_t RST_ALL   = 4'hF;  // every fabric reset asserted
    localparam word_t RST_NONE  = 4'h0;  // every fabric reset released
    localparam word_t LS_OFF    = 4'h0;  // all shifters closed
    localparam word_t LS_TO_FAB = 4'hA;  // processor-to-fabric only
    localparam word_t LS_BOTH   = 4'hF;  // both directions open

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_ALL,
        S_LS_OFF,
        S_LS_DOWN,
        S_W_HI1,
        S_W_LO,
        S_W_HI2,
        S_READY,
        S_W_DONE,
        S_REL_LS,
        S_REL_RST,
        S_ERROR
    } state_t;

    typedef struct packed {
        word_t fab_rst;
        word_t lvl_en;
        logic  prog_n;
    } drive_t;

    function automatic logic is_wait(state_t s);
        return (s == S_W_HI1) || (s == S_W_LO) || (s == S_W_HI2) || (s == S_W_DONE);
    endfunction

    function automatic logic is_busy(state_t s);
        return !((s == S_IDLE) || (s == S_READY) || (s == S_ERROR));
    endfunction

    // Level a wait state is looking for
    function automatic logic await_level(state_t s);
        return (s != S_W_LO);
    endfunction

    // Successor of a wait state once its level is seen
    function automatic state_t wait_exit(state_t s, logic part);
        case (s)
            S_W_HI1: return S_W_LO;
            S_W_LO:  return S_W_HI2;
            S_W_HI2: return S_READY;
            default: return part ? S_IDLE : S_REL_LS;
        endcase
    endfunction

endpackage

// File: rtl/plcfg_poll_timer.sv
`timescale 1ns/1ps
module plcfg_poll_timer #(
    parameter int POLL_CYCLES    = 2000,
    parameter int TIMEOUT_CYCLES = 250_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic poll_tick,
    output logic expired
);
    localparam int PW = $clog2(POLL_CYCLES + 1);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_CYCLES - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(TIMEOUT_CYCLES - 1);

    logic [PW-1:0] poll_cnt;
    logic [TW-1:0] tmo_cnt;

    assign poll_tick = run && (poll_cnt == POLL_LAST);
    assign expired   = run && (tmo_cnt == TMO_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            poll_cnt <= '0;
            tmo_cnt  <= '0;
        end else begin
            poll_cnt <= poll_tick ? '0 : poll_cnt + 1'b1;
            if (!expired)
                tmo_cnt <= tmo_cnt + 1'b1;
        end
    end

    AST_POLL_RANGE: assert property (@(posedge clk) disable iff (rst)
        poll_cnt <= POLL_LAST);                                         // R4
    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (poll_tick && !restart && run) |=> (poll_cnt == '0));           // R4
    AST_TMO_RANGE: assert property (@(posedge clk) disable iff (rst)
        tmo_cnt <= TMO_LAST);                                           // R5

endmodule

// File: rtl/plcfg_drive_regs.sv
`timescale 1ns/1ps
module plcfg_drive_regs
    import plcfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  state_t nxt,
    output drive_t drv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            drv.fab_rst <= RST_NONE;
            drv.lvl_en  <= LS_OFF;
            drv.prog_n  <= 1'b1;
        end else if (adv) begin
            case (nxt)
                S_RST_ALL: drv.fab_rst <= RST_ALL;
                S_LS_OFF:  drv.lvl_en  <= LS_OFF;
                S_LS_DOWN: drv.lvl_en  <= LS_TO_FAB;
                S_W_HI1:   drv.prog_n  <= 1'b1;
                S_W_LO:    drv.prog_n  <= 1'b0;
                S_W_HI2:   drv.prog_n  <= 1'b1;
                S_REL_LS:  drv.lvl_en  <= LS_BOTH;
                S_REL_RST: drv.fab_rst <= RST_NONE;
                default: ;
            endcase
        end
    end

    AST_STROBE_ONLY_WITH_SHIFT: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.prog_n) |-> (drv.lvl_en == LS_TO_FAB) && (drv.fab_rst == RST_ALL)); // R3

endmodule

// File: rtl/plcfg_bringup_seq.sv
`timescale 1ns/1ps
module plcfg_bringup_seq
    import plcfg_pkg::*;
#(
    parameter int POLL_CYCLES    = 2000,        // 20 us at 100 MHz
    parameter int TIMEOUT_CYCLES = 250_000_000  // 2.5 s at 100 MHz
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       finish_i,
    input  logic       partial_i,
    input  logic       init_i,
    input  logic       cfg_done_i,
    output logic [3:0] fab_rst_o,
    output logic [3:0] lvl_en_o,
    output logic       prog_n_o,
    output logic       busy_o,
    output logic       ready_o,
    output logic       done_o,
    output logic       timeout_o
);
    state_t state_q, state_d;
    logic   partial_q;
    logic   done_q;
    logic   poll_tick, expired;
    logic   sample;
    logic   accept_start;
    drive_t drv;

    assign sample       = (state_q == S_W_DONE) ? cfg_done_i : init_i;
    assign accept_start = start_i && ((state_q == S_IDLE) || (state_q == S_ERROR));

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE, S_ERROR:
                if (start_i) state_d = partial_i ? S_READY : S_RST_ALL;
            S_RST_ALL: state_d = S_LS_OFF;
            S_LS_OFF:  state_d = S_LS_DOWN;
            S_LS_DOWN: state_d = S_W_HI1;
            S_W_HI1, S_W_LO, S_W_HI2, S_W_DONE: begin
                if (poll_tick && (sample == await_level(state_q)))
                    state_d = wait_exit(state_q, partial_q);
                else if (expired)
                    state_d = S_ERROR;
            end
            S_READY:   if (finish_i) state_d = S_W_DONE;
            S_REL_LS:  state_d = S_REL_RST;
            S_REL_RST: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            partial_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_start)
                partial_q <= partial_i;
            done_q <= (state_d == S_IDLE) && (state_q != S_IDLE);
        end
    end

    plcfg_poll_timer #(
        .POLL_CYCLES   (POLL_CYCLES),
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (state_d != state_q),
        .run      (is_wait(state_q)),
        .poll_tick(poll_tick),
        .expired  (expired)
    );

    plcfg_drive_regs u_drive (
        .clk(clk),
        .rst(rst),
        .adv(state_d != state_q),
        .nxt(state_d),
        .drv(drv)
    );

    assign fab_rst_o = drv.fab_rst;
    assign lvl_en_o  = drv.lvl_en;
    assign prog_n_o  = drv.prog_n;
    assign busy_o    = is_busy(state_q);
    assign ready_o   = (state_q == S_READY);
    assign timeout_o = (state_q == S_ERROR);
    assign done_o    = done_q;

    AST_FULL_START: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !ready_o && start_i && !partial_i) |=> (fab_rst_o == RST_ALL) && busy_o); // R2
    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
        ((lvl_en_o == LS_TO_FAB) && ($past(lvl_en_o) != LS_TO_FAB))
            |-> ($past(lvl_en_o) == LS_OFF) && (fab_rst_o == RST_ALL));      // R2
    AST_STROBE_FOLLOWS_INIT: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_n_o) |-> $past(init_i));                                 // R3
    AST_TIMEOUT_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> $past(busy_o));                                 // R5
    AST_PARTIAL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !ready_o && start_i && partial_i)
            |=> ready_o && $stable(fab_rst_o) && $stable(lvl_en_o) && $stable(prog_n_o)); // R6
    AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        ((fab_rst_o == RST_NONE) && ($past(fab_rst_o) != RST_NONE)) |-> (lvl_en_o == LS_BOTH)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                                 // R7
    AST_ERROR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (timeout_o && !start_i)
            |=> timeout_o && $stable(fab_rst_o) && $stable(lvl_en_o) && $stable(prog_n_o)); // R9
    AST_FINISH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !ready_o && !timeout_o && !start_i && finish_i) |=> !busy_o); // R10

endmodule

// File: tb/plcfg_bringup_seq_bench.sv
`timescale 1ns/1ps
module plcfg_bringup_seq_bench;
    localparam int P = 4;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, finish_i = 0, partial_i = 0, init_i = 0, cfg_done_i = 0;
    logic [3:0] fab_rst_o, lvl_en_o;
    logic prog_n_o, busy_o, ready_o, done_o, timeout_o;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    plcfg_bringup_seq #(.POLL_CYCLES(P), .TIMEOUT_CYCLES(T)) u_plcfg_bringup_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .finish_i(finish_i),
        .partial_i(partial_i), .init_i(init_i), .cfg_done_i(cfg_done_i),
        .fab_rst_o(fab_rst_o), .lvl_en_o(lvl_en_o), .prog_n_o(prog_n_o),
        .busy_o(busy_o), .ready_o(ready_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [12:0] snap();
        return {fab_rst_o, lvl_en_o, prog_n_o, ready_o, timeout_o, busy_o, done_o};
    endfunction

    // first poll sample at or after latency L
    function automatic int first_poll(int L);
        return (L / P + 1) * P - 1;
    endfunction

    // Called at the start of wait cycle 0; returns whether the wait succeeded
    task automatic wait_phase(string req, bit on_done, bit lvl, int L, bit poke, output bit ok);
        int c = first_poll(L);
        int expn = (c <= T - 1) ? c + 1 : T;
        logic [12:0] s0 = snap();
        int n = 0;
        bit changed = 0;
        for (int i = 0; i < T + 4 && !changed; i++) begin
            if (on_done) cfg_done_i = (i >= L) ? lvl : !lvl;
            else         init_i     = (i >= L) ? lvl : !lvl;
            start_i  = poke && (i == 0);
            finish_i = poke && (i == 0);
            step();
            start_i  = 0;
            finish_i = 0;
            n++;
            if (snap() !== s0) changed = 1;
        end
        ok = (c <= T - 1);
        check({req, " exit cycle"}, n, expn);
        check({req, " timeout flag"}, int'(timeout_o), int'(!ok));
    endtask

    task automatic error_hold();
        logic [12:0] s0 = snap();
        repeat (3) step();
        check("R9 error holds outputs", int'(snap()), int'(s0));
        check("R9 timeout held", int'(timeout_o), 1);
        check("R10 busy low in error", int'(busy_o), 0);
    endtask

    task automatic full_run(int l0, int l1, int l2, int l3, bit poke);
        bit ok;
        logic [3:0] lvl_prev = lvl_en_o;
        partial_i = 0;
        start_i = 1;
        step();
        start_i = 0;
        check("R2 resets asserted first", int'(fab_rst_o), 'hF);
        check("R2 shifters untouched while resets assert", int'(lvl_en_o), int'(lvl_prev));
        check("R10 busy after start", int'(busy_o), 1);
        check("R9 timeout cleared by start", int'(timeout_o), 0);
        step();
        check("R2 shifters closed", int'(lvl_en_o), 'h0);
        step();
        check("R2 shifters down only", int'(lvl_en_o), 'hA);
        check("R2 resets still asserted", int'(fab_rst_o), 'hF);
        step();
        check("R3 strobe high first", int'(prog_n_o), 1);
        wait_phase("R3 R4 init high 1", 0, 1, l0, poke, ok);
        if (!ok) begin error_hold(); return; end
        check("R3 strobe low", int'(prog_n_o), 0);
        wait_phase("R3 R4 init low", 0, 0, l1, 0, ok);
        if (!ok) begin error_hold(); return; end
        check("R3 strobe high again", int'(prog_n_o), 1);
        wait_phase("R3 R4 init high 2", 0, 1, l2, 0, ok);
        if (!ok) begin error_hold(); return; end
        check("R3 ready after handshake", int'(ready_o), 1);
        check("R10 busy low in ready", int'(busy_o), 0);
        start_i = 1;
        step();
        start_i = 0;
        check("R10 start ignored in ready", int'(ready_o), 1);
        check("R10 start ignored in ready, resets", int'(fab_rst_o), 'hF);
        finish_i = 1;
        cfg_done_i = 0;
        step();
        finish_i = 0;
        check("R7 finish leaves ready", int'(ready_o), 0);
        check("R10 busy during finish", int'(busy_o), 1);
        wait_phase("R7 R4 config done", 1, 1, l3, 0, ok);
        if (!ok) begin error_hold(); return; end
        check("R7 shifters opened both ways", int'(lvl_en_o), 'hF);
        check("R7 resets still asserted", int'(fab_rst_o), 'hF);
        check("R7 no early done", int'(done_o), 0);
        step();
        check("R7 resets released", int'(fab_rst_o), 'h0);
        step();
        check("R7 done pulse", int'(done_o), 1);
        check("R10 busy low after done", int'(busy_o), 0);
        step();
        check("R7 done is one cycle", int'(done_o), 0);
        finish_i = 1;
        step();
        finish_i = 0;
        check("R10 finish ignored in idle", int'(busy_o), 0);
        check("R10 finish ignored in idle, ready", int'(ready_o), 0);
    endtask

    task automatic partial_run(int l3, string tag);
        bit ok;
        logic [8:0] keep = {fab_rst_o, lvl_en_o, prog_n_o};
        partial_i = 1;
        start_i = 1;
        step();
        start_i = 0;
        partial_i = 0;
        check({"R6 ready at once ", tag}, int'(ready_o), 1);
        check({"R6 fabric untouched ", tag}, int'({fab_rst_o, lvl_en_o, prog_n_o}), int'(keep));
        check({"R6 timeout cleared ", tag}, int'(timeout_o), 0);
        finish_i = 1;
        cfg_done_i = 0;
        step();
        finish_i = 0;
        check({"R8 busy in finish ", tag}, int'(busy_o), 1);
        wait_phase("R8 R4 partial config done", 1, 1, l3, 0, ok);
        if (!ok) begin error_hold(); return; end
        check({"R8 done pulse ", tag}, int'(done_o), 1);
        check({"R8 fabric untouched ", tag}, int'({fab_rst_o, lvl_en_o, prog_n_o}), int'(keep));
        step();
        check({"R8 done one cycle ", tag}, int'(done_o), 0);
    endtask

    initial begin
        for (int k = 0; k < 200000; k++) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int lat[10] = '{0, 1, 2, 3, 4, 7, 8, 13, 19, 20};
        repeat (3) step();
        rst = 0;
        step();
        check("R1 reset resets word", int'(fab_rst_o), 'h0);
        check("R1 reset shifter word", int'(lvl_en_o), 'h0);
        check("R1 reset strobe", int'(prog_n_o), 1);
        check("R1 reset flags", int'({busy_o, ready_o, done_o, timeout_o}), 0);

        // Latency sweep over each wait; 20 lands beyond the window (R5)
        for (int w = 0; w < 4; w++) begin
            for (int j = 0; j < 10; j++) begin
                int L = lat[j];
                full_run(w == 0 ? L : 0, w == 1 ? L : 0, w == 2 ? L : 0, w == 3 ? L : 0,
                         (w == 0) && (L == 4));
                if (L == 20)
                    check("R5 timeout for late level", int'(timeout_o), 1);
            end
        end

        // Partial load from idle after a full load
        full_run(5, 6, 9, 2, 0);
        partial_run(5, "from idle");

        // Partial load from an error that left the strobe low
        full_run(0, 20, 0, 0, 0);
        check("R9 error with strobe low", int'(prog_n_o), 0);
        partial_run(11, "from error");

        // Partial finish timing out, then recovery by a full load
        partial_run(20, "late done");
        check("R5 partial done timeout", int'(timeout_o), 1);
        full_run(0, 0, 0, 0, 0);
        check("R9 recovery ends in idle", int'({busy_o, ready_o, timeout_o}), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule